// File: doc/BRIEF.md
# SPI Serial Flash Slave Model

This block is a synthesizable model of the command side of an SPI NOR serial flash. It runs on a fast system clock and oversamples the chip select, serial clock and serial data input pins through a synchronizer. It collects an 8-bit instruction followed by address, dummy or data bytes, and drives a serial data output with an output-enable. It backs a small byte array organised in pages and sectors. It also holds a status byte that carries a write-in-progress flag and a write-enable latch.

Program, erase and status-write operations are committed only when chip select rises. They then run as internal cycles whose length is set by parameters. During an internal cycle the affected bytes are rewritten one per system clock. A deep power-down state silences the device until a signature read releases it. The block suits test benches and FPGA prototypes that need a flash device which behaves like the real one at the pins.

Top module: `spif_slave`

## Requirements
- R1: After reset the output enable is low, and a status read (opcode 05h) returns 00h. Bit 0 of the status byte is write-in-progress and bit 1 is the write-enable latch.
- R2: The output enable is low whenever chip select is high. It rises only during a status read, an array read or a signature read that is being served.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it. Opcode 01h followed by one data byte stores bits 7:2 of that byte into status bits 7:2 and starts a status-write cycle.
- R4: Opcode 03h followed by a 3-byte address, most significant byte first, returns array bytes from that address. Each byte is shifted out MSB first, one bit per serial clock. The address increments after each byte and wraps from the top of the array to address 0.
- R5: Opcode 02h with a 3-byte address and one or more data bytes programs the page that holds the address. Each stored byte becomes old AND new. The byte address wraps within the 256-byte page. Without the write-enable latch set, the command has no effect.
- R6: A status write, program or erase is cancelled, with no change to the array or the status byte, unless chip select rises after a whole number of bytes. The enable latch stays set after a cancelled command.
- R7: Opcode D8h with an address sets every byte of the 1 KB sector that holds that address to FFh and leaves the other sectors unchanged. Opcode C7h sets the whole array to FFh.
- R8: Write-in-progress reads 1 for the programmed cycle count of each status write, program or erase. The enable latch clears when the cycle ends. While a cycle runs, every instruction except the status read is ignored, and a read produces no output.
- R9: After opcode B9h the device enters deep power-down. There, every instruction except ABh is ignored, and a status or array read leaves the output disabled.
- R10: Opcode ABh followed by 3 dummy bytes shifts out the signature byte 14h, repeated for as long as the clock runs. When chip select rises after ABh, deep power-down ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out of the device |
| miso_oe | output | 1 | Output enable for the miso pad; low means high impedance |

## Verification
The assertions rely on two conditions at the inputs. Chip select changes only while the serial clock is low. Each serial clock phase lasts at least a few system clocks longer than the synchronizer depth, so every edge is seen exactly once, and a chip-select edge never lands on the same system clock as a serial clock edge. The bench drives each half period of the serial clock for six system clocks and holds the serial clock low for six system clocks around every chip-select edge. The input bit changes on the falling edge, which keeps it stable when it is captured on the rising edge.

// File: rtl/spif_pkg.sv
package spif_pkg;
   typedef enum logic [7:0] {
      OP_WRSR = 8'h01,
      OP_PP   = 8'h02,
      OP_READ = 8'h03,
      OP_WRDI = 8'h04,
      OP_RDSR = 8'h05,
      OP_WREN = 8'h06,
      OP_RES  = 8'hAB,
      OP_DP   = 8'hB9,
      OP_BE   = 8'hC7,
      OP_SE   = 8'hD8
   } opcode_e;

   typedef enum logic [1:0] {
      JOB_PP,
      JOB_SE,
      JOB_BE,
      JOB_WRSR
   } job_e;
endpackage

// File: rtl/spif_pin_sync.sv
module spif_pin_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] lvl_o
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("spif_pin_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_o <= RST_VAL;
            else        lvl_o <= pin_i;
         end
      end else begin : g_chain
         logic [STAGES*W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[(STAGES-1)*W-1:0], pin_i};
         end
         assign lvl_o = chain[STAGES*W-1 -: W];
      end
   endgenerate
endmodule

// File: rtl/spif_array.sv
module spif_array #(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end
   assign rdata = cells[raddr];
endmodule

// File: rtl/spif_timer.sv
module spif_timer #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] limit,
   output logic          busy,
   output logic [CW-1:0] idx,
   output logic          done
);
   logic [CW-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         lim_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         idx   <= '0;
         lim_q <= limit;
      end else if (busy) begin
         if (done) busy <= 1'b0;
         else      idx  <= idx + 1'b1;
      end
   end
   assign done = busy && (idx == lim_q - 1'b1);

   a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(done)) |-> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/spif_slave.sv
module spif_slave
   import spif_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int SECTOR_W    = 10,
   parameter int PAGE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 16,
   parameter int PP_CYCLES   = 300,
   parameter int SE_CYCLES   = 1100,
   parameter int BE_CYCLES   = 4200,
   parameter int WRSR_CYCLES = 40,
   parameter logic [7:0] SIGNATURE = 8'h14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   output logic miso,
   output logic miso_oe
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PAGE   = 1 << PAGE_W;
   localparam int SECTOR = 1 << SECTOR_W;

   generate
      if (ADDR_W <= 8 || ADDR_W > 24) begin : g_bad_aw
         $error("spif_slave: ADDR_W out of range");
      end
      if (PAGE_W > 8 || SECTOR_W < PAGE_W || ADDR_W < SECTOR_W) begin : g_bad_geom
         $error("spif_slave: page and sector geometry inconsistent");
      end
      if (PP_CYCLES < PAGE || SE_CYCLES < SECTOR || BE_CYCLES < DEPTH || WRSR_CYCLES < 1) begin : g_bad_time
         $error("spif_slave: cycle counts shorter than the span they rewrite");
      end
      if (BE_CYCLES >= (1 << CNT_W)) begin : g_bad_cnt
         $error("spif_slave: CNT_W too narrow");
      end
   endgenerate

   // pin synchronizer: {mosi, sclk, cs_n}
   logic [2:0] lvl;
   logic       cs_prev, sck_prev;
   spif_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i({mosi, sclk, cs_n}), .lvl_o(lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev  <= 1'b1;
         sck_prev <= 1'b0;
      end else begin
         cs_prev  <= lvl[0];
         sck_prev <= lvl[1];
      end
   end

   logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall, din;
   assign cs_act   = !lvl[0];
   assign cs_fall  = !lvl[0] && cs_prev;
   assign cs_rise  = lvl[0] && !cs_prev;
   assign sck_rise = cs_act && lvl[1] && !sck_prev;
   assign sck_fall = cs_act && !lvl[1] && sck_prev;
   assign din      = lvl[2];

   // shared state
   logic [2:0]        bit_cnt, byte_cnt;
   logic [6:0]        shreg;
   logic [7:0]        opcode;
   logic              live_q;
   logic [ADDR_W-1:0] addr;
   logic [5:0]        wrsr_val, sr_hi;
   logic [PAGE_W-1:0] pg_ptr;
   logic [7:0]        pg_buf [PAGE];
   logic [PAGE-1:0]   pg_val;
   logic [7:0]        out_sr;
   logic              out_en, load_pend, wel, dpd;
   job_e              job;
   logic [ADDR_W-PAGE_W-1:0] job_base;

   logic              busy, done, tmr_start;
   logic [CNT_W-1:0]  idx, tmr_lim;
   logic              arr_we;
   logic [ADDR_W-1:0] arr_waddr, arr_raddr;
   logic [7:0]        arr_wdata, arr_rdata;

   // byte assembly and command classification
   logic       byte_done, live_now, wants_out;
   logic [7:0] new_byte, op_now;
   assign byte_done = sck_rise && (bit_cnt == 3'd7);
   assign new_byte  = {shreg, din};
   assign op_now    = (byte_cnt == 3'd0) ? new_byte : opcode;

   function automatic logic live_of(input logic [7:0] op, input logic dp, input logic bz);
      return (!dp || op == OP_RES) && (!bz || op == OP_RDSR);
   endfunction

   assign live_now  = (byte_cnt == 3'd0) ? live_of(new_byte, dpd, busy) : live_q;
   assign wants_out = live_now && ((op_now == OP_RDSR) ||
                      ((op_now == OP_READ || op_now == OP_RES) && byte_cnt >= 3'd3));

   // commit at deselect
   logic commit, aligned, st_pp, st_se, st_be, st_wrsr;
   assign commit  = cs_rise && live_q && (byte_cnt != 3'd0);
   assign aligned = (bit_cnt == 3'd0);
   assign st_pp   = commit && aligned && wel && opcode == OP_PP   && byte_cnt >= 3'd5;
   assign st_se   = commit && aligned && wel && opcode == OP_SE   && byte_cnt == 3'd4;
   assign st_be   = commit && aligned && wel && opcode == OP_BE   && byte_cnt == 3'd1;
   assign st_wrsr = commit && aligned && wel && opcode == OP_WRSR && byte_cnt == 3'd2;
   assign tmr_start = st_pp | st_se | st_be | st_wrsr;

   always_comb begin
      if (st_pp)      tmr_lim = CNT_W'(PP_CYCLES);
      else if (st_se) tmr_lim = CNT_W'(SE_CYCLES);
      else if (st_be) tmr_lim = CNT_W'(BE_CYCLES);
      else            tmr_lim = CNT_W'(WRSR_CYCLES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0; byte_cnt <= '0; shreg <= '0; opcode <= '0; live_q <= 1'b0;
         addr <= '0; wrsr_val <= '0; sr_hi <= '0; pg_ptr <= '0; pg_val <= '0;
         out_sr <= '0; out_en <= 1'b0; load_pend <= 1'b0; wel <= 1'b0; dpd <= 1'b0;
         job <= JOB_PP; job_base <= '0;
      end else begin
         if (cs_fall) begin
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            out_en    <= 1'b0;
            load_pend <= 1'b0;
            if (!busy) pg_val <= '0;
         end
         if (sck_rise) begin
            shreg   <= new_byte[6:0];
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (byte_done) begin
            if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 1'b1;
            load_pend <= wants_out;
            if (byte_cnt == 3'd0) begin
               opcode <= new_byte;
               live_q <= live_now;
            end else if (live_q) begin
               if (byte_cnt <= 3'd3 && opcode != OP_RES)
                  addr <= {addr[ADDR_W-9:0], new_byte};
               if (byte_cnt == 3'd3) pg_ptr <= new_byte[PAGE_W-1:0];
               if (byte_cnt == 3'd1 && opcode == OP_WRSR) wrsr_val <= new_byte[7:2];
               if (byte_cnt >= 3'd4 && opcode == OP_PP) begin
                  pg_val[pg_ptr] <= 1'b1;
                  pg_ptr         <= pg_ptr + 1'b1;
               end
            end
         end
         if (sck_fall) begin
            if (load_pend) begin
               load_pend <= 1'b0;
               out_en    <= 1'b1;
               if (opcode == OP_RDSR)      out_sr <= {sr_hi, wel, busy};
               else if (opcode == OP_RES)  out_sr <= SIGNATURE;
               else begin
                  out_sr <= arr_rdata;
                  addr   <= addr + 1'b1;
               end
            end else begin
               out_sr <= {out_sr[6:0], 1'b0};
            end
         end
         if (commit && aligned && byte_cnt == 3'd1) begin
            if (opcode == OP_WREN) wel <= 1'b1;
            if (opcode == OP_WRDI) wel <= 1'b0;
            if (opcode == OP_DP)   dpd <= 1'b1;
         end
         if (commit && opcode == OP_RES) dpd <= 1'b0;
         if (tmr_start) begin
            job_base <= addr[ADDR_W-1:PAGE_W];
            if (st_pp)      job <= JOB_PP;
            else if (st_se) job <= JOB_SE;
            else if (st_be) job <= JOB_BE;
            else            job <= JOB_WRSR;
         end
         if (done) begin
            wel <= 1'b0;
            if (job == JOB_WRSR) sr_hi <= wrsr_val;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (byte_done && live_q && byte_cnt >= 3'd4 && opcode == OP_PP)
         pg_buf[pg_ptr] <= new_byte;
   end

   // internal cycle: one byte rewritten per system clock
   spif_timer #(.CW(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .limit(tmr_lim),
      .busy(busy), .idx(idx), .done(done));

   logic [ADDR_W-1:0] full_base;
   assign full_base = {job_base, {PAGE_W{1'b0}}};

   always_comb begin
      arr_we    = 1'b0;
      arr_wdata = 8'hFF;
      arr_waddr = idx[ADDR_W-1:0];
      case (job)
         JOB_PP: begin
            arr_waddr = {job_base, idx[PAGE_W-1:0]};
            arr_we    = busy && idx < CNT_W'(PAGE) && pg_val[idx[PAGE_W-1:0]];
            arr_wdata = arr_rdata & pg_buf[idx[PAGE_W-1:0]];
         end
         JOB_SE: begin
            arr_waddr = {full_base[ADDR_W-1:SECTOR_W], idx[SECTOR_W-1:0]};
            arr_we    = busy && idx < CNT_W'(SECTOR);
         end
         JOB_BE: arr_we = busy && idx < CNT_W'(DEPTH);
         default: arr_we = 1'b0;
      endcase
   end
   assign arr_raddr = busy ? arr_waddr : addr;

   spif_array #(.AW(ADDR_W)) u_array (
      .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
      .raddr(arr_raddr), .rdata(arr_rdata));

   assign miso    = out_sr[7];
   assign miso_oe = out_en && cs_act;

   a_r8_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_start |-> !busy);
   a_r8_wel_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);
   a_r9_dpd_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      dpd |-> !tmr_start);
   a_r9_dpd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && dpd) |-> (opcode == OP_RES));
   a_r10_release_by_sig: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dpd) |-> (opcode == OP_RES));
   a_r8_array_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !arr_we);
endmodule

// File: tb/spif_slave_test.sv
module spif_slave_test;
   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic miso, miso_oe;
   int checks = 0, errors = 0;
   logic oe_seen;
   logic [7:0] got [4];
   bit finished = 0;
   localparam int HALF = 6;

   always #4 clk = ~clk;

   spif_slave uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
                   .mosi(mosi), .miso(miso), .miso_oe(miso_oe));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         wait_clk(HALF);
         rx[i] = miso;
         if (miso_oe) oe_seen = 1'b1;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic xbits(input int n);
      for (int i = 0; i < n; i++) begin
         mosi = 1'b0; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
      end
   endtask

   task automatic sel();
      cs_n = 1'b0; oe_seen = 1'b0; wait_clk(HALF);
   endtask

   task automatic desel();
      wait_clk(HALF); cs_n = 1'b1; wait_clk(HALF);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      sel(); xbyte(op, d); desel();
   endtask

   task automatic send_addr(input logic [23:0] a);
      logic [7:0] d;
      xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
   endtask

   task automatic rdsr(output logic [7:0] s, output logic oe);
      logic [7:0] d;
      sel(); xbyte(8'h05, d); xbyte(8'h00, s); oe = oe_seen; desel();
   endtask

   task automatic rd(input logic [23:0] a, input int n);
      logic [7:0] d;
      sel(); xbyte(8'h03, d); send_addr(a);
      for (int i = 0; i < n; i++) begin xbyte(8'h00, d); got[i] = d; end
      desel();
   endtask

   task automatic pp(input logic [23:0] a, input int n, input logic [7:0] b0,
                     input logic [7:0] b1, input logic [7:0] b2);
      logic [7:0] d;
      sel(); xbyte(8'h02, d); send_addr(a);
      xbyte(b0, d);
      if (n > 1) xbyte(b1, d);
      if (n > 2) xbyte(b2, d);
      desel();
   endtask

   task automatic wait_idle();
      logic [7:0] s; logic oe;
      for (int i = 0; i < 200; i++) begin
         rdsr(s, oe);
         if (s[0] == 1'b0) return;
      end
      chk("R8 cycle never ended", 8'h01, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] s; logic oe;
      chk("R1 oe after reset", {7'b0, miso_oe}, 8'h00);
      rdsr(s, oe);
      chk("R1 status after reset", s, 8'h00);
      chk("R2 oe during status read", {7'b0, oe}, 8'h01);
      chk("R2 oe with cs high", {7'b0, miso_oe}, 8'h00);
   endtask

   task automatic t_bulk();
      logic [7:0] s; logic oe;
      cmd1(8'h06);
      rdsr(s, oe);
      chk("R3 wel set", s, 8'h02);
      cmd1(8'hC7);
      rdsr(s, oe);
      chk("R8 wip during bulk erase", s, 8'h03);
      wait_idle();
      rdsr(s, oe);
      chk("R8 wel cleared after cycle", s, 8'h00);
      rd(24'h000000, 2);
      chk("R7 bulk erase addr 0", got[0], 8'hFF);
      chk("R7 bulk erase addr 1", got[1], 8'hFF);
      rd(24'h000FFE, 1);
      chk("R7 bulk erase top", got[0], 8'hFF);
   endtask

   task automatic t_wel_wrsr();
      logic [7:0] s, d; logic oe;
      cmd1(8'h06); cmd1(8'h04);
      rdsr(s, oe);
      chk("R3 wrdi clears wel", s, 8'h00);
      cmd1(8'h06);
      sel(); xbyte(8'h01, d); xbyte(8'hFF, d); desel();
      wait_idle();
      rdsr(s, oe);
      chk("R3 status write bits 7:2", s, 8'hFC);
      cmd1(8'h06);
      sel(); xbyte(8'h01, d); xbyte(8'h00, d); desel();
      wait_idle();
      rdsr(s, oe);
      chk("R3 status write restore", s, 8'h00);
   endtask

   task automatic t_program();
      pp(24'h000010, 1, 8'hA5, 8'h00, 8'h00);
      wait_idle();
      rd(24'h000010, 1);
      chk("R5 program without wel ignored", got[0], 8'hFF);
      cmd1(8'h06); pp(24'h000010, 2, 8'hA5, 8'h3C, 8'h00); wait_idle();
      rd(24'h000010, 2);
      chk("R4/R5 program byte 0", got[0], 8'hA5);
      chk("R4/R5 program byte 1", got[1], 8'h3C);
      cmd1(8'h06); pp(24'h000010, 1, 8'h0F, 8'h00, 8'h00); wait_idle();
      rd(24'h000010, 1);
      chk("R5 program ANDs old and new", got[0], 8'h05);
      cmd1(8'h06); pp(24'h0001FE, 3, 8'h11, 8'h22, 8'h33); wait_idle();
      rd(24'h0001FE, 2);
      chk("R5 page tail byte 1FE", got[0], 8'h11);
      chk("R5 page tail byte 1FF", got[1], 8'h22);
      rd(24'h000100, 1);
      chk("R5 page wrap to 100", got[0], 8'h33);
      rd(24'h000200, 1);
      chk("R5 next page untouched", got[0], 8'hFF);
   endtask

   task automatic t_read_wrap();
      cmd1(8'h06); pp(24'h000FFF, 1, 8'h77, 8'h00, 8'h00); wait_idle();
      rd(24'h000FFF, 3);
      chk("R4 read top byte", got[0], 8'h77);
      chk("R4 read wraps to 0", got[1], 8'hFF);
      chk("R4 read continues at 1", got[2], 8'hFF);
   endtask

   task automatic t_cancel();
      logic [7:0] s, d; logic oe;
      cmd1(8'h06);
      sel(); xbyte(8'h02, d); send_addr(24'h000020); xbyte(8'h00, d); xbits(3); desel();
      rdsr(s, oe);
      chk("R6 ragged program not started, wel kept", s, 8'h02);
      rd(24'h000020, 1);
      chk("R6 ragged program left array", got[0], 8'hFF);
      sel(); xbyte(8'hD8, d); send_addr(24'h000010); xbits(5); desel();
      rdsr(s, oe);
      chk("R6 ragged erase not started", s, 8'h02);
      rd(24'h000010, 1);
      chk("R6 ragged erase left array", got[0], 8'h05);
      sel(); xbyte(8'h01, d); xbyte(8'hFF, d); xbits(2); desel();
      wait_idle();
      rdsr(s, oe);
      chk("R6 ragged status write ignored", s, 8'h02);
      cmd1(8'h04);
   endtask

   task automatic t_sector();
      cmd1(8'h06); pp(24'h000400, 1, 8'h12, 8'h00, 8'h00); wait_idle();
      cmd1(8'h06); pp(24'h000800, 1, 8'h34, 8'h00, 8'h00); wait_idle();
      cmd1(8'h06);
      begin
         logic [7:0] d;
         sel(); xbyte(8'hD8, d); send_addr(24'h0005AB); desel();
      end
      wait_idle();
      rd(24'h000400, 1);
      chk("R7 sector start erased", got[0], 8'hFF);
      rd(24'h0007FF, 1);
      chk("R7 sector end erased", got[0], 8'hFF);
      rd(24'h000800, 1);
      chk("R7 next sector kept", got[0], 8'h34);
      rd(24'h0001FE, 1);
      chk("R7 previous sector kept", got[0], 8'h11);
   endtask

   task automatic t_busy();
      logic [7:0] s, d; logic oe;
      cmd1(8'h06);
      sel(); xbyte(8'hD8, d); send_addr(24'h000C00); desel();
      rd(24'h000800, 1);
      chk("R8 read while busy gives no output", {7'b0, oe_seen}, 8'h00);
      rdsr(s, oe);
      chk("R8 status while busy", s, 8'h03);
      chk("R8 status read served while busy", {7'b0, oe}, 8'h01);
      pp(24'h000800, 1, 8'h00, 8'h00, 8'h00);
      wait_idle();
      rd(24'h000800, 1);
      chk("R8 program while busy ignored", got[0], 8'h34);
   endtask

   task automatic t_dpd();
      logic [7:0] s, d, r1, r2; logic oe;
      cmd1(8'hB9);
      rdsr(s, oe);
      chk("R9 status read silent in power-down", {7'b0, oe}, 8'h00);
      rd(24'h000800, 1);
      chk("R9 array read silent in power-down", {7'b0, oe_seen}, 8'h00);
      cmd1(8'h06);
      sel(); xbyte(8'hAB, d); xbyte(8'h00, d); xbyte(8'h00, d); xbyte(8'h00, d);
      xbyte(8'h00, r1); xbyte(8'h00, r2); oe = oe_seen; desel();
      chk("R10 signature first", r1, 8'h14);
      chk("R10 signature repeated", r2, 8'h14);
      chk("R10 signature drives output", {7'b0, oe}, 8'h01);
      rdsr(s, oe);
      chk("R10 released, wren was ignored", s, 8'h00);
      chk("R10 released, status served", {7'b0, oe}, 8'h01);
      chk("R2 oe low after deselect", {7'b0, miso_oe}, 8'h00);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_bulk();
      t_wel_wrsr();
      t_program();
      t_read_wrap();
      t_cancel();
      t_sector();
      t_busy();
      t_dpd();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clk(190000);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual running expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule